// File: doc/BRIEF.md
# Ethernet PHY Management Register Bank

This block is the management-side register bank of a 10/100 Ethernet PHY model. A station manager reaches it through a parallel command port. Each command carries a PHY address, a register index, write data and separate read and write strobes. The bank holds sixteen 16-bit registers. A few of them have fixed identity and capability reset values. The status and identity registers ignore writes. The control register has a soft-reset bit that clears itself. The serial management framing that would sit in front of the bank is a separate block.

A link-up input comes from the line side. It is not tied to the bank's clock, so it passes through a two-flop synchroniser. The synchronised level drives a two-state machine that records which link level the registers currently reflect. The state is `LNK_DOWN` or `LNK_UP`. The machine moves from `LNK_DOWN` to `LNK_UP` when the synchronised input reads 1, and from `LNK_UP` to `LNK_DOWN` when it reads 0. Each transition is a link event. A link event sets or clears the link bit in the status register and adjusts the link-partner ability register. A soft reset also applies this reflection, using the level the machine holds after that edge.

Reads return registered data one clock after the strobe, together with a one-cycle valid pulse. Only one PHY address answers. A read aimed at any other address returns all ones.

Top module: `mgmt_phy_regs`

## Requirements
- R1: After reset, with the link input low, the register reads are: index 0 (control) 0x1000, index 1 (status) 0x7848, index 2 (identity high) 0x2000, index 3 (identity low) 0x5C90, index 4 (advertisement) 0x01E1, and 0x0000 for every other index from 5 to 15.
- R2: A read or write with a register index of 16 or more, sent to the answering PHY address, changes no register and does not alias onto a lower index. Such a read returns 0x0000.
- R3: A write to index 0 with bit 15 set reloads every register with its reset value and does not store the written word. A following read of index 0 gives 0x1000.
- R4: A write to index 0 with bit 15 clear stores the written word unchanged.
- R5: Writes to index 1, index 2 and index 3 are ignored.
- R6: Indices 4 to 15 store any written word.
- R7: A change of the link to up sets status bit 2 and ORs 0x01E1 into index 5.
- R8: A change of the link to down clears status bit 2 and ANDs index 5 with 0x01FF.
- R9: A soft reset applies the link reflection again with the current link level. With the link up, index 5 reads 0x01E1 and status reads 0x784C. With the link down, they read 0x0000 and 0x7848.
- R10: Only PHY address 1 answers. Writes to any other PHY address are ignored, and reads of any other PHY address return 0xFFFF.
- R11: Each read strobe gives exactly one valid pulse with data on the next clock. A read in the same cycle as a write to the same index returns the value from before the write.
- R12: The link input passes through two flops. The registers take the new link level at the third rising edge after the input changes, so reads sampled at the first three edges still return the old value.
- R13: When a write to index 5 lands in the same cycle as a link event, the written word is stored first and the link mask is applied on top of it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mgmt_phy_addr_i | input | PHY_ADDR_W (5) | PHY address of the command |
| mgmt_reg_addr_i | input | REG_ADDR_W (5) | Register index of the command |
| mgmt_wdata_i | input | DATA_W (16) | Write data |
| mgmt_wr_i | input | 1 | Write strobe, one cycle per command |
| mgmt_rd_i | input | 1 | Read strobe, one cycle per command |
| link_up_i | input | 1 | Asynchronous link-up level |
| mgmt_rdata_o | output | DATA_W (16) | Registered read data |
| mgmt_rvalid_o | output | 1 | One-cycle pulse marking valid read data |

## Verification
The host write port and the link reflection can both modify the link-partner register at the same clock edge. The bench makes them meet by changing the link input and then timing a write to index 5 so that it is sampled on the exact edge of the link event. That edge is the third one after the input change. It then reads back 0x01E1 after writing 0x0000 as the link rises, and 0x01FF after writing 0xFFFF as the link falls. A soft reset that coincides with link reflection is judged the same way, by reading the partner and status registers after the reset.

// File: rtl/mgmt_phy_pkg.sv
package mgmt_phy_pkg;

    localparam int REG_W     = 16;
    localparam int REG_COUNT = 16;

    // Register indices whose behaviour differs from plain storage
    localparam int IDX_CTRL    = 0;
    localparam int IDX_STAT    = 1;
    localparam int IDX_ID_HI   = 2;
    localparam int IDX_ID_LO   = 3;
    localparam int IDX_ADV     = 4;
    localparam int IDX_PARTNER = 5;

    localparam int SOFT_RST_BIT  = 15;
    localparam int STAT_LINK_BIT = 2;

    localparam logic [REG_W-1:0] PARTNER_UP_SET    = 16'h01E1;
    localparam logic [REG_W-1:0] PARTNER_DOWN_KEEP = 16'h01FF;

    // Link level currently reflected in the register bank
    typedef enum logic {
        LNK_DOWN = 1'b0,
        LNK_UP   = 1'b1
    } link_state_e;

    function automatic logic [REG_W-1:0] reset_value(input int idx);
        case (idx)
            IDX_CTRL:  return 16'h1000;
            IDX_STAT:  return 16'h7848;
            IDX_ID_HI: return 16'h2000;
            IDX_ID_LO: return 16'h5C90;
            IDX_ADV:   return 16'h01E1;
            default:   return 16'h0000;
        endcase
    endfunction

    function automatic logic is_protected(input int idx);
        return (idx == IDX_STAT) || (idx == IDX_ID_HI) || (idx == IDX_ID_LO);
    endfunction

endpackage

// File: rtl/mgmt_link_sync.sv
module mgmt_link_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= {pipe_q[STAGES-2:0], async_i};
        end
    end

    assign sync_o = pipe_q[STAGES-1];

endmodule

// File: rtl/mgmt_phy_bank.sv
module mgmt_phy_bank
    import mgmt_phy_pkg::*;
#(
    parameter int NREGS  = REG_COUNT,
    parameter int DATA_W = REG_W,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           load_defaults,
    input  logic                           wr_hit,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [DATA_W-1:0]              wr_data,
    input  logic                           link_apply,
    input  logic                           link_val,
    output logic [NREGS-1:0][DATA_W-1:0]   regs_o
);

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        localparam logic [DATA_W-1:0] RST_VAL = DATA_W'(reset_value(g));
        localparam logic              LOCKED  = is_protected(g);

        logic [DATA_W-1:0] q;
        logic [DATA_W-1:0] nxt;

        always_comb begin
            nxt = q;
            if (load_defaults) begin
                nxt = RST_VAL;
            end else if (wr_hit && (wr_idx == IDX_W'(g)) && !LOCKED) begin
                nxt = wr_data;
            end
            // link reflection sits on top of whatever the write produced
            if (link_apply) begin
                if (g == IDX_STAT) begin
                    nxt[STAT_LINK_BIT] = link_val;
                end
                if (g == IDX_PARTNER) begin
                    nxt = link_val ? (nxt | DATA_W'(PARTNER_UP_SET))
                                   : (nxt & DATA_W'(PARTNER_DOWN_KEEP));
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= RST_VAL;
            end else begin
                q <= nxt;
            end
        end

        assign regs_o[g] = q;
    end

endmodule

// File: rtl/mgmt_phy_regs.sv
module mgmt_phy_regs
    import mgmt_phy_pkg::*;
#(
    parameter int PHY_ADDR_W  = 5,
    parameter int REG_ADDR_W  = 5,
    parameter int DATA_W      = REG_W,
    parameter int NREGS       = REG_COUNT,
    parameter int OWN_PHY     = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PHY_ADDR_W-1:0] mgmt_phy_addr_i,
    input  logic [REG_ADDR_W-1:0] mgmt_reg_addr_i,
    input  logic [DATA_W-1:0]     mgmt_wdata_i,
    input  logic                  mgmt_wr_i,
    input  logic                  mgmt_rd_i,
    input  logic                  link_up_i,
    output logic [DATA_W-1:0]     mgmt_rdata_o,
    output logic                  mgmt_rvalid_o
);

    localparam int IDX_W = $clog2(NREGS);

    logic                         link_s;
    logic                         addr_hit;
    logic                         idx_ok;
    logic [IDX_W-1:0]             idx;
    logic                         wr_hit;
    logic                         soft_rst;
    logic                         link_event;
    logic [NREGS-1:0][DATA_W-1:0] regs;
    link_state_e                  state_q;
    link_state_e                  state_d;

    mgmt_link_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (link_up_i),
        .sync_o  (link_s)
    );

    // command decode
    assign addr_hit = (mgmt_phy_addr_i == PHY_ADDR_W'(OWN_PHY));
    assign idx_ok   = ({1'b0, mgmt_reg_addr_i} < (REG_ADDR_W+1)'(NREGS));
    assign idx      = mgmt_reg_addr_i[IDX_W-1:0];
    assign wr_hit   = mgmt_wr_i && addr_hit && idx_ok;
    assign soft_rst = wr_hit && (idx == IDX_W'(IDX_CTRL)) && mgmt_wdata_i[SOFT_RST_BIT];

    // next-state logic for the reflected link level
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LNK_DOWN: if (link_s)  state_d = LNK_UP;
            LNK_UP:   if (!link_s) state_d = LNK_DOWN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LNK_DOWN;
        end else begin
            state_q <= state_d;
        end
    end

    assign link_event = (state_d != state_q);

    mgmt_phy_bank #(.NREGS(NREGS), .DATA_W(DATA_W)) u_bank (
        .clk           (clk),
        .rst_n         (rst_n),
        .load_defaults (soft_rst),
        .wr_hit        (wr_hit),
        .wr_idx        (idx),
        .wr_data       (mgmt_wdata_i),
        .link_apply    (link_event || soft_rst),
        .link_val      (state_d == LNK_UP),
        .regs_o        (regs)
    );

    // registered read port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mgmt_rvalid_o <= 1'b0;
            mgmt_rdata_o  <= '0;
        end else begin
            mgmt_rvalid_o <= mgmt_rd_i;
            if (mgmt_rd_i) begin
                if (!addr_hit) begin
                    mgmt_rdata_o <= '1;
                end else if (idx_ok) begin
                    mgmt_rdata_o <= regs[idx];
                end else begin
                    mgmt_rdata_o <= '0;
                end
            end
        end
    end

endmodule

// File: rtl/mgmt_phy_regs_chk.sv
module mgmt_phy_regs_chk
    import mgmt_phy_pkg::*;
#(
    parameter int PHY_ADDR_W = 5,
    parameter int REG_ADDR_W = 5,
    parameter int DATA_W     = REG_W,
    parameter int NREGS      = REG_COUNT,
    parameter int OWN_PHY    = 1
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [PHY_ADDR_W-1:0]        phy_addr,
    input logic [REG_ADDR_W-1:0]        reg_addr,
    input logic [DATA_W-1:0]            wdata,
    input logic                         wr,
    input logic                         rd,
    input logic                         link_s,
    input logic [DATA_W-1:0]            rdata,
    input logic                         rvalid,
    input logic [NREGS-1:0][DATA_W-1:0] regs
);

    assert_valid_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> rvalid);

    assert_no_spurious_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> !rvalid);

    assert_foreign_phy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && phy_addr != PHY_ADDR_W'(OWN_PHY)) |=> (rdata == '1));

    assert_soft_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && phy_addr == PHY_ADDR_W'(OWN_PHY) && reg_addr == '0 && wdata[SOFT_RST_BIT])
        |=> (regs[IDX_CTRL] == DATA_W'(16'h1000)));

    assert_id_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        regs[IDX_ID_HI] == DATA_W'(16'h2000) && regs[IDX_ID_LO] == DATA_W'(16'h5C90));

    assert_status_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (regs[IDX_STAT] | DATA_W'(16'h0004)) == DATA_W'(16'h784C));

    assert_link_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_s) |=> (regs[IDX_STAT][STAT_LINK_BIT] &&
                           ((regs[IDX_PARTNER] & DATA_W'(PARTNER_UP_SET)) == DATA_W'(PARTNER_UP_SET))));

    assert_link_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(link_s) |=> (!regs[IDX_STAT][STAT_LINK_BIT] &&
                           ((regs[IDX_PARTNER] & ~DATA_W'(PARTNER_DOWN_KEEP)) == '0)));

endmodule

bind mgmt_phy_regs mgmt_phy_regs_chk #(
    .PHY_ADDR_W (PHY_ADDR_W),
    .REG_ADDR_W (REG_ADDR_W),
    .DATA_W     (DATA_W),
    .NREGS      (NREGS),
    .OWN_PHY    (OWN_PHY)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .phy_addr (mgmt_phy_addr_i),
    .reg_addr (mgmt_reg_addr_i),
    .wdata    (mgmt_wdata_i),
    .wr       (mgmt_wr_i),
    .rd       (mgmt_rd_i),
    .link_s   (link_s),
    .rdata    (mgmt_rdata_o),
    .rvalid   (mgmt_rvalid_o),
    .regs     (regs)
);

// File: tb/test_mgmt_phy_regs.sv
module test_mgmt_phy_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  phy_addr = '0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] wdata = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic        link = 1'b0;
    logic [15:0] rdata;
    logic        rvalid;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [15:0] val;
        string       tag;
    } exp_t;

    exp_t sb[$];
    exp_t mon_item;

    always #10 clk = ~clk;

    mgmt_phy_regs i_mgmt_phy_regs (
        .clk             (clk),
        .rst_n           (rst_n),
        .mgmt_phy_addr_i (phy_addr),
        .mgmt_reg_addr_i (reg_addr),
        .mgmt_wdata_i    (wdata),
        .mgmt_wr_i       (wr),
        .mgmt_rd_i       (rd),
        .link_up_i       (link),
        .mgmt_rdata_o    (rdata),
        .mgmt_rvalid_o   (rvalid)
    );

    function automatic logic [15:0] rv(input int i);
        case (i)
            0:       return 16'h1000;
            1:       return 16'h7848;
            2:       return 16'h2000;
            3:       return 16'h5C90;
            4:       return 16'h01E1;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [15:0] pat(input int i);
        return 16'(i * 16'h1357 + 16'h0F0F);
    endfunction

    // Monitor: pops expected items as read data appears
    always @(negedge clk) begin
        if (rst_n && rvalid) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R11 unexpected valid actual %h expected none", rdata);
            end else begin
                mon_item = sb.pop_front();
                if (rdata !== mon_item.val) begin
                    errors++;
                    $display("FAIL %s actual %h expected %h", mon_item.tag, rdata, mon_item.val);
                end
            end
        end
    end

    // Driver: called at posedge+2, leaves at the next posedge+2
    task automatic op(input logic r, input logic w, input logic [4:0] pa,
                      input logic [4:0] ra, input logic [15:0] d,
                      input logic [15:0] exp, input string tag);
        phy_addr = pa;
        reg_addr = ra;
        wdata    = d;
        wr       = w;
        rd       = r;
        if (r) sb.push_back('{exp, tag});
        @(posedge clk);
        #2;
        wr = 1'b0;
        rd = 1'b0;
    endtask

    task automatic wr_reg(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] d);
        op(1'b0, 1'b1, pa, ra, d, 16'h0, "");
    endtask

    task automatic rd_reg(input logic [4:0] pa, input logic [4:0] ra,
                          input logic [15:0] exp, input string tag);
        op(1'b1, 1'b0, pa, ra, 16'h0, exp, tag);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        idle(1);

        // R1: reset state at the ports, then every register
        checks++;
        if (rvalid !== 1'b0 || rdata !== 16'h0) begin
            errors++;
            $display("FAIL R1 outputs actual %b/%h expected 0/0000", rvalid, rdata);
        end
        for (int i = 0; i < 16; i++) rd_reg(5'd1, 5'(i), rv(i), "R1");

        // R4: ordinary control write
        wr_reg(5'd1, 5'd0, 16'h3100);
        rd_reg(5'd1, 5'd0, 16'h3100, "R4");

        // R6: plain storage in 4..15
        for (int i = 4; i < 16; i++) wr_reg(5'd1, 5'(i), pat(i));
        for (int i = 4; i < 16; i++) rd_reg(5'd1, 5'(i), pat(i), "R6");

        // R5: protected registers
        wr_reg(5'd1, 5'd1, 16'h0000);
        wr_reg(5'd1, 5'd2, 16'hFFFF);
        wr_reg(5'd1, 5'd3, 16'h0000);
        rd_reg(5'd1, 5'd1, 16'h7848, "R5");
        rd_reg(5'd1, 5'd2, 16'h2000, "R5");
        rd_reg(5'd1, 5'd3, 16'h5C90, "R5");

        // R2: out-of-range indices, no aliasing
        wr_reg(5'd1, 5'd16, 16'hBEEF);
        wr_reg(5'd1, 5'd20, 16'hCAFE);
        rd_reg(5'd1, 5'd0, 16'h3100, "R2");
        rd_reg(5'd1, 5'd4, pat(4), "R2");
        rd_reg(5'd1, 5'd16, 16'h0000, "R2");
        rd_reg(5'd1, 5'd31, 16'h0000, "R2");

        // R10: foreign PHY addresses
        wr_reg(5'd2, 5'd4, 16'h0000);
        wr_reg(5'd0, 5'd0, 16'h8000);
        rd_reg(5'd1, 5'd4, pat(4), "R10");
        rd_reg(5'd1, 5'd0, 16'h3100, "R10");
        rd_reg(5'd0, 5'd0, 16'hFFFF, "R10");
        rd_reg(5'd31, 5'd1, 16'hFFFF, "R10");

        // R11: read and write to the same index in one cycle
        op(1'b1, 1'b1, 5'd1, 5'd6, 16'h1234, pat(6), "R11");
        rd_reg(5'd1, 5'd6, 16'h1234, "R11");

        // R3: soft reset
        wr_reg(5'd1, 5'd0, 16'hC2AA);
        rd_reg(5'd1, 5'd0, 16'h1000, "R3");
        rd_reg(5'd1, 5'd4, 16'h01E1, "R3");
        rd_reg(5'd1, 5'd6, 16'h0000, "R3");
        rd_reg(5'd1, 5'd15, 16'h0000, "R3");

        // R12 and R7: link rises; the update lands on the third edge
        link = 1'b1;
        rd_reg(5'd1, 5'd1, 16'h7848, "R12");
        rd_reg(5'd1, 5'd1, 16'h7848, "R12");
        rd_reg(5'd1, 5'd1, 16'h7848, "R12");
        rd_reg(5'd1, 5'd1, 16'h784C, "R7");
        rd_reg(5'd1, 5'd5, 16'h01E1, "R7");
        wr_reg(5'd1, 5'd5, 16'hF00F);
        rd_reg(5'd1, 5'd5, 16'hF00F, "R6");

        // R8: link falls
        link = 1'b0;
        idle(4);
        rd_reg(5'd1, 5'd1, 16'h7848, "R8");
        rd_reg(5'd1, 5'd5, 16'h000F, "R8");

        // R9: soft reset with the link up, then with it down
        link = 1'b1;
        idle(4);
        rd_reg(5'd1, 5'd5, 16'h01EF, "R7");
        wr_reg(5'd1, 5'd0, 16'h8000);
        rd_reg(5'd1, 5'd5, 16'h01E1, "R9");
        rd_reg(5'd1, 5'd1, 16'h784C, "R9");
        link = 1'b0;
        idle(4);
        wr_reg(5'd1, 5'd5, 16'hFFFF);
        wr_reg(5'd1, 5'd0, 16'h8000);
        rd_reg(5'd1, 5'd5, 16'h0000, "R9");
        rd_reg(5'd1, 5'd1, 16'h7848, "R9");

        // R13: write to the partner register on the link-event edge
        link = 1'b1;
        idle(2);
        wr_reg(5'd1, 5'd5, 16'h0000);
        rd_reg(5'd1, 5'd5, 16'h01E1, "R13");
        link = 1'b0;
        idle(2);
        wr_reg(5'd1, 5'd5, 16'hFFFF);
        rd_reg(5'd1, 5'd5, 16'h01FF, "R13");
        rd_reg(5'd1, 5'd1, 16'h7848, "R13");

        idle(3);
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R11 pending reads actual %0d expected 0", sb.size());
        end
        done = 1;
        summary();
    end

endmodule